// File: doc/BRIEF.md
# Media operation command decoder

This block takes one media-operations command at a time and turns it into either an immediate reply or a background job. The command arrives as a single beat. The beat carries a class byte, a subclass byte, a 32-bit range count and the payload length in bytes. For discovery commands it also carries a 16-bit start index and a 16-bit entry count. The two reserved header bytes are not decoded.

A discovery command returns a page of the fixed capability table together with the granularity and the table size. The table, in order, is (0,0), (1,0), (1,1).

A sanitize or zero command reads its address ranges from a valid/ready stream and checks every one of them. Only when all of them are accepted does it replay the whole list, in arrival order, to a downstream fill engine. Each beat of that replay carries the fill byte for the subclass. The reply then reports that a background job has started.

Top module: `mop_decoder`

## Requirements
- R1: Class 0/subclass 0 is discovery, class 1/subclass 0 is sanitize with fill byte 0x0F, class 1/subclass 1 is zero with fill byte 0x00, and every other pair replies status 4 (unsupported). Status codes: 0 success, 1 background started, 2 invalid input, 3 invalid payload length.
- R2: A payload under 8 bytes replies status 3 for any class. A discovery payload under 12 bytes replies status 3. A sanitize/zero payload under 8 + 16 × range count bytes replies status 3.
- R3: A discovery command with a nonzero range count, or with a start index above 3, replies status 2.
- R4: A successful discovery reply reports granularity 64 and total 3. Entry k sits in `rsp_pairs_o[16k+15:16k]`, with the class in the upper byte and the subclass in the lower byte. The entries follow table order from the start index, and unused slots read zero.
- R5: The returned count is the smaller of the requested count and the number of table entries from the start index to the end of the table, so a start index of 3 returns zero entries.
- R6: A range is valid only if its start and its length are multiples of 64, its length is nonzero, and start + length (computed without wrap) is no greater than MEDIA_SIZE. If any range of a command is invalid, the reply is status 2 and nothing reaches the fill engine.
- R7: The fill engine sees no beat until every range of the command has been accepted and validated. It then receives all ranges in arrival order, with the subclass fill byte on each beat and `fill_last_o` set on the final beat. Status 1 follows the final handoff.
- R8: A sanitize/zero command with a range count of 0 replies status 0 without consuming ranges or driving the fill engine.
- R9: A sanitize/zero command whose range count exceeds MAX_RANGES (with a sufficient payload length) replies status 2 without consuming ranges.
- R10: After reset only `cmd_ready_o` is high. A command that needs no ranges gets its reply in the cycle after acceptance. `rsp_valid_o` lasts exactly one cycle.
- R11: While a fill beat is stalled, its contents and its valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command beat valid |
| cmd_ready_o | output | 1 | Decoder idle, command accepted |
| cmd_class_i | input | 8 | Operation class |
| cmd_subclass_i | input | 8 | Operation subclass |
| cmd_range_cnt_i | input | 32 | Number of address ranges |
| cmd_len_i | input | 16 | Payload length in bytes |
| cmd_disc_start_i | input | 16 | Discovery start index |
| cmd_disc_num_i | input | 16 | Discovery entries requested |
| rng_valid_i | input | 1 | Range beat valid |
| rng_ready_o | output | 1 | Range beat accepted |
| rng_start_i | input | 64 | Range start address |
| rng_len_i | input | 64 | Range length in bytes |
| fill_valid_o | output | 1 | Fill beat valid |
| fill_ready_i | input | 1 | Fill engine accepts beat |
| fill_start_o | output | 64 | Fill range start |
| fill_len_o | output | 64 | Fill range length |
| fill_byte_o | output | 8 | Fill value |
| fill_last_o | output | 1 | Last range of the list |
| rsp_valid_o | output | 1 | Reply pulse |
| rsp_status_o | output | 3 | Reply status code |
| rsp_gran_o | output | 64 | Range granularity (discovery) |
| rsp_total_o | output | 16 | Table size (discovery) |
| rsp_count_o | output | 16 | Entries returned (discovery) |
| rsp_pairs_o | output | 48 | Returned class/subclass pairs |

## Verification
The bench builds the decoder with MAX_RANGES = 4 and MEDIA_SIZE = 1 MiB. With a range buffer that small, the over-count rejection is easy to hit, as is a list that fills the buffer to its last slot. With media that small, random ranges often land exactly on the end of the media or just past it. Random fill-engine stalls exercise the hold behaviour, and start addresses near 2^64 check that the end-address sum does not wrap.

// File: rtl/mop_pkg.sv
package mop_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_BG      = 3'd1,
    ST_BAD_IN  = 3'd2,
    ST_BAD_LEN = 3'd3,
    ST_UNSUP   = 3'd4
  } mop_status_e;

  localparam int TBL_N      = 3;
  localparam int HDR_BYTES  = 8;
  localparam int DISC_BYTES = 12;
  localparam int PAIR_W     = 16;

  typedef struct packed {
    logic [63:0] start;
    logic [63:0] len;
  } mop_range_t;

  function automatic logic [15:0] tbl_pair(input logic [15:0] idx);
    case (idx)
      16'd0:   return 16'h0000;
      16'd1:   return 16'h0100;
      16'd2:   return 16'h0101;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mop_disc_page.sv
module mop_disc_page
  import mop_pkg::*;
(
  input  logic [15:0]              start_i,
  input  logic [15:0]              num_i,
  output logic [15:0]              cnt_o,
  output logic [TBL_N*PAIR_W-1:0]  pairs_o
);

  logic [15:0] remain;

  always_comb begin
    remain = (start_i >= 16'(TBL_N)) ? 16'd0 : 16'(TBL_N) - start_i;
    cnt_o  = (num_i < remain) ? num_i : remain;
  end

  for (genvar k = 0; k < TBL_N; k++) begin : g_slot
    logic [15:0] pos;
    assign pos = start_i + 16'(k);
    assign pairs_o[PAIR_W*k +: PAIR_W] = (16'(k) < cnt_o) ? tbl_pair(pos) : '0;
  end

endmodule

// File: rtl/mop_range_check.sv
module mop_range_check #(
  parameter logic [63:0] MEDIA_SIZE = 64'h1_0000_0000,
  parameter int          GRAN_LOG2  = 6
) (
  input  logic [63:0] start_i,
  input  logic [63:0] len_i,
  output logic        ok_o
);

  logic [64:0] end_addr;
  logic        aligned;

  always_comb begin
    end_addr = {1'b0, start_i} + {1'b0, len_i};
    aligned  = (start_i[GRAN_LOG2-1:0] == '0) && (len_i[GRAN_LOG2-1:0] == '0);
    ok_o     = aligned && (len_i != '0) && (end_addr <= {1'b0, MEDIA_SIZE});
  end

endmodule

// File: rtl/mop_range_buf.sv
module mop_range_buf
  import mop_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  mop_range_t       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output mop_range_t       rd_data_o
);

  mop_range_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];

endmodule

// File: rtl/mop_decoder.sv
module mop_decoder
  import mop_pkg::*;
#(
  parameter int          MAX_RANGES = 8,
  parameter logic [63:0] MEDIA_SIZE = 64'h1_0000_0000,
  parameter int          GRAN_LOG2  = 6,
  localparam int         IDX_W      = $clog2(MAX_RANGES),
  localparam int         CNT_W      = $clog2(MAX_RANGES + 1),
  localparam int         PAIRS_W    = TBL_N * PAIR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [7:0]         cmd_class_i,
  input  logic [7:0]         cmd_subclass_i,
  input  logic [31:0]        cmd_range_cnt_i,
  input  logic [15:0]        cmd_len_i,
  input  logic [15:0]        cmd_disc_start_i,
  input  logic [15:0]        cmd_disc_num_i,
  input  logic               rng_valid_i,
  output logic               rng_ready_o,
  input  logic [63:0]        rng_start_i,
  input  logic [63:0]        rng_len_i,
  output logic               fill_valid_o,
  input  logic               fill_ready_i,
  output logic [63:0]        fill_start_o,
  output logic [63:0]        fill_len_o,
  output logic [7:0]         fill_byte_o,
  output logic               fill_last_o,
  output logic               rsp_valid_o,
  output logic [2:0]         rsp_status_o,
  output logic [63:0]        rsp_gran_o,
  output logic [15:0]        rsp_total_o,
  output logic [15:0]        rsp_count_o,
  output logic [PAIRS_W-1:0] rsp_pairs_o
);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_EMIT, S_RESP} state_e;

  state_e             state_q;
  mop_status_e        status_q, imm_status;
  logic               disc_q;
  logic [15:0]        count_q;
  logic [PAIRS_W-1:0] pairs_q;
  logic [7:0]         fill_q;
  logic [CNT_W-1:0]   n_rng_q, n_last;
  logic [IDX_W-1:0]   idx_q;
  logic               bad_q;

  // command decode
  logic        is_disc, is_san, is_zero;
  logic [36:0] need_len;
  logic        go_collect, cmd_fire;
  logic [15:0] page_cnt;
  logic [PAIRS_W-1:0] page_pairs;

  assign cmd_ready_o = (state_q == S_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign is_disc     = (cmd_class_i == 8'd0) && (cmd_subclass_i == 8'd0);
  assign is_san      = (cmd_class_i == 8'd1) && (cmd_subclass_i == 8'd0);
  assign is_zero     = (cmd_class_i == 8'd1) && (cmd_subclass_i == 8'd1);
  assign need_len    = {1'b0, cmd_range_cnt_i, 4'b0} + 37'(HDR_BYTES);

  mop_disc_page u_page (
    .start_i (cmd_disc_start_i),
    .num_i   (cmd_disc_num_i),
    .cnt_o   (page_cnt),
    .pairs_o (page_pairs)
  );

  always_comb begin
    imm_status = ST_OK;
    go_collect = 1'b0;
    if (cmd_len_i < 16'(HDR_BYTES)) begin
      imm_status = ST_BAD_LEN;
    end else if (is_disc) begin
      if (cmd_len_i < 16'(DISC_BYTES))                        imm_status = ST_BAD_LEN;
      else if (cmd_range_cnt_i != '0 ||
               cmd_disc_start_i > 16'(TBL_N))                 imm_status = ST_BAD_IN;
      else                                                    imm_status = ST_OK;
    end else if (is_san || is_zero) begin
      if (cmd_range_cnt_i == '0)                              imm_status = ST_OK;
      else if ({21'b0, cmd_len_i} < need_len)                 imm_status = ST_BAD_LEN;
      else if (cmd_range_cnt_i > 32'(MAX_RANGES))             imm_status = ST_BAD_IN;
      else                                                    go_collect = 1'b1;
    end else begin
      imm_status = ST_UNSUP;
    end
  end

  // range intake and replay
  logic       rng_ok, rng_fire, fill_fire, at_last;
  mop_range_t wr_rng, rd_rng;

  assign rng_ready_o  = (state_q == S_COLLECT);
  assign rng_fire     = rng_valid_i && rng_ready_o;
  assign fill_valid_o = (state_q == S_EMIT);
  assign fill_fire    = fill_valid_o && fill_ready_i;
  assign n_last       = n_rng_q - 1'b1;
  assign at_last      = (CNT_W'(idx_q) == n_last);
  assign wr_rng       = '{start: rng_start_i, len: rng_len_i};

  mop_range_check #(.MEDIA_SIZE(MEDIA_SIZE), .GRAN_LOG2(GRAN_LOG2)) u_check (
    .start_i (rng_start_i),
    .len_i   (rng_len_i),
    .ok_o    (rng_ok)
  );

  mop_range_buf #(.DEPTH(MAX_RANGES)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (rng_fire),
    .wr_idx_i  (idx_q),
    .wr_data_i (wr_rng),
    .rd_idx_i  (idx_q),
    .rd_data_o (rd_rng)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      disc_q   <= 1'b0;
      count_q  <= '0;
      pairs_q  <= '0;
      fill_q   <= '0;
      n_rng_q  <= '0;
      idx_q    <= '0;
      bad_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_fire) begin
          disc_q  <= is_disc && (imm_status == ST_OK);
          count_q <= (is_disc && imm_status == ST_OK) ? page_cnt : '0;
          pairs_q <= (is_disc && imm_status == ST_OK) ? page_pairs : '0;
          fill_q  <= is_san ? 8'h0F : 8'h00;
          n_rng_q <= CNT_W'(cmd_range_cnt_i);
          idx_q   <= '0;
          bad_q   <= 1'b0;
          status_q <= imm_status;
          state_q  <= go_collect ? S_COLLECT : S_RESP;
        end
        S_COLLECT: if (rng_fire) begin
          if (at_last) begin
            idx_q <= '0;
            if (bad_q || !rng_ok) begin
              status_q <= ST_BAD_IN;
              state_q  <= S_RESP;
            end else begin
              state_q  <= S_EMIT;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            bad_q <= bad_q || !rng_ok;
          end
        end
        S_EMIT: if (fill_fire) begin
          if (at_last) begin
            status_q <= ST_BG;
            state_q  <= S_RESP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign fill_start_o = rd_rng.start;
  assign fill_len_o   = rd_rng.len;
  assign fill_byte_o  = fill_q;
  assign fill_last_o  = fill_valid_o && at_last;

  assign rsp_valid_o  = (state_q == S_RESP);
  assign rsp_status_o = status_q;
  assign rsp_gran_o   = disc_q ? (64'd1 << GRAN_LOG2) : '0;
  assign rsp_total_o  = disc_q ? 16'(TBL_N) : '0;
  assign rsp_count_o  = count_q;
  assign rsp_pairs_o  = pairs_q;

  // checks
  assert_one_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_ready_o, rng_ready_o, fill_valid_o, rsp_valid_o}));

  assert_fill_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o && !fill_ready_i |=> fill_valid_o && $stable(fill_start_o)
      && $stable(fill_len_o) && $stable(fill_byte_o));

  assert_fill_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> fill_start_o[GRAN_LOG2-1:0] == '0 && fill_len_o[GRAN_LOG2-1:0] == '0
      && fill_len_o != '0 && ({1'b0, fill_start_o} + {1'b0, fill_len_o}) <= {1'b0, MEDIA_SIZE});

  assert_fill_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (fill_byte_o == 8'h0F || fill_byte_o == 8'h00));

  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_page_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_count_o <= 16'(TBL_N));

  assert_bg_after_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_status_o == ST_BG |-> $past(fill_valid_o && fill_ready_i && fill_last_o));

endmodule

// File: tb/sim_mop_decoder.sv
module sim_mop_decoder;

  localparam int          MAX_R = 4;
  localparam logic [63:0] MSIZE = 64'h10_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [7:0]  cmd_cls = '0, cmd_sub = '0;
  logic [31:0] cmd_cnt = '0;
  logic [15:0] cmd_len = '0, cmd_ds = '0, cmd_dn = '0;
  logic        rng_valid = 1'b0, rng_ready;
  logic [63:0] rng_start = '0, rng_len = '0;
  logic        fill_valid, fill_ready = 1'b0, fill_last;
  logic [63:0] fill_start, fill_len;
  logic [7:0]  fill_byte;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [63:0] rsp_gran;
  logic [15:0] rsp_total, rsp_count;
  logic [47:0] rsp_pairs;

  always #2 clk = ~clk;

  mop_decoder #(.MAX_RANGES(MAX_R), .MEDIA_SIZE(MSIZE)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_class_i(cmd_cls), .cmd_subclass_i(cmd_sub), .cmd_range_cnt_i(cmd_cnt),
    .cmd_len_i(cmd_len), .cmd_disc_start_i(cmd_ds), .cmd_disc_num_i(cmd_dn),
    .rng_valid_i(rng_valid), .rng_ready_o(rng_ready),
    .rng_start_i(rng_start), .rng_len_i(rng_len),
    .fill_valid_o(fill_valid), .fill_ready_i(fill_ready),
    .fill_start_o(fill_start), .fill_len_o(fill_len), .fill_byte_o(fill_byte),
    .fill_last_o(fill_last),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_gran_o(rsp_gran),
    .rsp_total_o(rsp_total), .rsp_count_o(rsp_count), .rsp_pairs_o(rsp_pairs)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] r_start [8];
  logic [63:0] r_len   [8];
  logic [63:0] g_start [8];
  logic [63:0] g_len   [8];
  logic [7:0]  g_byte  [8];
  logic        g_last  [8];
  int          n_got = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // fill engine model: set ready first, then record a beat that fires at the next edge
  always @(negedge clk) begin
    fill_ready = ($urandom % 3) != 0;
    if (fill_valid && fill_ready && n_got < 8) begin
      g_start[n_got] = fill_start;
      g_len[n_got]   = fill_len;
      g_byte[n_got]  = fill_byte;
      g_last[n_got]  = fill_last;
      n_got++;
    end
  end

  function automatic bit rng_good(input logic [63:0] s, input logic [63:0] l);
    if (s % 64 != 0 || l % 64 != 0 || l == 0) return 0;
    if (l > MSIZE) return 0;
    return s <= MSIZE - l;
  endfunction

  function automatic int exp_stat(input int cls, input int sub, input longint cnt,
                                  input int len, input int ds);
    if (len < 8) return 3;
    if (cls == 0 && sub == 0) begin
      if (len < 12) return 3;
      if (cnt != 0 || ds > 3) return 2;
      return 0;
    end
    if (cls == 1 && (sub == 0 || sub == 1)) begin
      if (cnt == 0) return 0;
      if (longint'(len) < 8 + 16 * cnt) return 3;
      if (cnt > MAX_R) return 2;
      for (int i = 0; i < cnt; i++) if (!rng_good(r_start[i], r_len[i])) return 2;
      return 1;
    end
    return 4;
  endfunction

  function automatic logic [15:0] tbl(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0100;
      2: return 16'h0101;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic run_cmd(input int cls, input int sub, input longint cnt, input int len,
                         input int ds, input int dn);
    int est, cyc, nfeed, expc, rem;
    bit imm;
    logic [47:0] ep;
    est   = exp_stat(cls, sub, cnt, len, ds);
    nfeed = (cls == 1 && (sub == 0 || sub == 1) && len >= 8 && cnt != 0 &&
             longint'(len) >= 8 + 16 * cnt && cnt <= MAX_R) ? int'(cnt) : 0;
    imm   = (nfeed == 0);
    n_got = 0;
    @(negedge clk);
    cmd_cls = 8'(cls); cmd_sub = 8'(sub); cmd_cnt = 32'(cnt);
    cmd_len = 16'(len); cmd_ds = 16'(ds); cmd_dn = 16'(dn);
    cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R10 idle ready", 64'(cmd_ready), 1);
    @(posedge clk);
    cyc = 0;
    fork
      begin
        int i = 0;
        while (i < nfeed) begin
          @(negedge clk);
          if (($urandom % 4) != 0) begin
            rng_valid = 1'b1; rng_start = r_start[i]; rng_len = r_len[i];
            if (rng_ready) i++;
          end else begin
            rng_valid = 1'b0;
          end
        end
        if (nfeed > 0) begin
          @(negedge clk);
          rng_valid = 1'b0;
        end
      end
      begin
        do begin
          @(negedge clk);
          cmd_valid = 1'b0;
          cyc++;
          if (!rsp_valid && n_got > 0 && est != 1)
            chk(0, "R6 fill before reject", 64'(n_got), 0);
        end while (!rsp_valid && cyc < 500);
      end
    join
    chk(rsp_valid == 1'b1, "R10 reply seen", 64'(rsp_valid), 1);
    if (imm) chk(cyc == 1, "R10 immediate reply cycle", 64'(cyc), 1);
    chk(rsp_status == 3'(est), (est == 4) ? "R1 status" : (est == 3) ? "R2 status" :
        (cls == 0) ? "R3 status" : (cnt == 0) ? "R8 status" : (cnt > MAX_R) ? "R9 status" :
        "R6 status", 64'(rsp_status), 64'(est));
    if (cls == 0 && sub == 0 && est == 0) begin
      rem  = (ds >= 3) ? 0 : 3 - ds;
      expc = (dn < rem) ? dn : rem;
      ep   = '0;
      for (int k = 0; k < expc; k++) ep[16*k +: 16] = tbl(ds + k);
      chk(rsp_count == 16'(expc), "R5 page count", 64'(rsp_count), 64'(expc));
      chk(rsp_pairs == ep, "R4 page pairs", 64'(rsp_pairs), 64'(ep));
      chk(rsp_gran == 64 && rsp_total == 3, "R4 gran/total", 64'(rsp_gran), 64);
    end
    expc = (est == 1) ? int'(cnt) : 0;
    chk(n_got == expc, (cnt == 0) ? "R8 fill beats" : "R7 fill beat count", 64'(n_got), 64'(expc));
    if (est == 1) begin
      for (int k = 0; k < expc; k++) begin
        chk(g_start[k] == r_start[k] && g_len[k] == r_len[k], "R7 fill order",
            g_start[k], r_start[k]);
        chk(g_byte[k] == ((sub == 0) ? 8'h0F : 8'h00), "R1 fill byte",
            64'(g_byte[k]), (sub == 0) ? 64'h0F : 64'h00);
        chk(g_last[k] == (k == expc - 1), "R7 last flag", 64'(g_last[k]), 64'(k == expc - 1));
      end
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 reply pulse", 64'(rsp_valid), 0);
  endtask

  task automatic rand_range(input int i);
    int m = $urandom % 8;
    r_len[i]   = 64'((($urandom % 32) + 1) * 64);
    r_start[i] = 64'(($urandom % (MSIZE / 64)) * 64);
    if (r_start[i] + r_len[i] > MSIZE && m != 0) r_start[i] = MSIZE - r_len[i];
    case (m)
      1: r_start[i] = r_start[i] + 64'(($urandom % 63) + 1);
      2: r_len[i]   = 0;
      3: r_start[i] = 64'hFFFF_FFFF_FFFF_FFC0;
      default: ;
    endcase
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1 && !rng_ready && !fill_valid && !rsp_valid, "R10 reset state",
        {60'b0, cmd_ready, rng_ready, fill_valid, rsp_valid}, 64'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed
    run_cmd(2, 0, 0, 16, 0, 1);
    run_cmd(0, 1, 0, 16, 0, 1);
    run_cmd(1, 2, 0, 16, 0, 1);
    run_cmd(1, 0, 1, 4, 0, 0);
    run_cmd(0, 0, 0, 10, 0, 3);
    run_cmd(0, 0, 1, 16, 0, 3);
    run_cmd(0, 0, 0, 16, 4, 3);
    run_cmd(0, 0, 0, 16, 3, 3);
    run_cmd(0, 0, 0, 16, 0, 5);
    run_cmd(0, 0, 0, 12, 1, 1);
    run_cmd(0, 0, 0, 12, 2, 0);
    run_cmd(1, 0, 0, 8, 0, 0);
    run_cmd(1, 0, 5, 200, 0, 0);
    run_cmd(1, 1, 2, 39, 0, 0);
    r_start[0] = 0;            r_len[0] = 64;
    r_start[1] = 64'h8_0000;   r_len[1] = 64'h1000;
    r_start[2] = MSIZE - 128;  r_len[2] = 128;
    r_start[3] = 64'h40;       r_len[3] = 64'h40;
    run_cmd(1, 0, 4, 72, 0, 0);
    run_cmd(1, 1, 4, 72, 0, 0);
    r_start[1] = MSIZE - 64;   r_len[1] = 128;
    run_cmd(1, 1, 2, 40, 0, 0);
    r_start[1] = 64'h20;       r_len[1] = 64;
    run_cmd(1, 0, 2, 40, 0, 0);
    r_start[1] = 64'hFFFF_FFFF_FFFF_FFC0; r_len[1] = 128;
    run_cmd(1, 0, 2, 40, 0, 0);

    // random
    for (int t = 0; t < 300; t++) begin
      int cls, sub, cnt, len, ds, dn;
      cls = ($urandom % 8 == 0) ? 2 : (($urandom % 3 == 0) ? 0 : 1);
      sub = ($urandom % 8 == 0) ? 2 : $urandom % 2;
      cnt = ($urandom % 6 == 0) ? 5 : $urandom % 5;
      if (cls == 0 && ($urandom % 3) != 0) cnt = 0;
      len = (cls == 0) ? 12 : 8 + 16 * cnt;
      if ($urandom % 6 == 0) len = len - 1 - ($urandom % 6);
      if (len < 0) len = 0;
      ds = $urandom % 5;
      dn = $urandom % 5;
      for (int i = 0; i < 4; i++) rand_range(i);
      run_cmd(cls, sub, cnt, len, ds, dn);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule